// File: doc/BRIEF.md
# Multi-Depth Power-Down Clock Controller

This block decides, every reference clock cycle, which of three peripheral functions may receive a clock and whether the shared crystal oscillator may run. The functions are two serial channels (A and B) and a floppy disk function. Software supplies one enable bit per function and a small power-control word: a power-down bit, a crystal-stop select and a mask for an external active-low power-down pin. The floppy function can also raise a low-power request and later a wake indication.

Three depths are possible. In the shallowest, single functions lose their clock while everything else runs. In the middle depth, every function clock stops but the crystal keeps running. In the deepest, the crystal stops as well. When the crystal restarts, a stabilization counter runs on the free-running reference clock. While it runs, a pending flag is raised and the floppy ready indication is held low. Waking from the two shallower depths needs no wait. Each function also gets a gated clock, produced by a latch-based gate that is glitch-free.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While reset is asserted, and until the first edge after internal release, all clock enables and gated clocks are 0, `xtal_en` is 1, `stab_pend` is 0 and `fdc_ready` is 0.
- R2: `fn_en` bit 0 controls serial channel A, bit 1 channel B and bit 2 the floppy function. A clear bit forces the matching `clk_en` bit to 0 one edge later and leaves the other bits alone.
- R3: With `xtal_sel`=0, a one-cycle `fdc_lp_req` pulse clears `clk_en[2]` only. `xtal_en` stays 1. A later `fdc_wake` pulse restores the floppy enable one edge later, with no stabilization wait.
- R4: With `xtal_sel`=0, `pd_sw`=1 forces all three enables to 0 while `xtal_en` stays 1. Clearing `pd_sw` restores them one edge later, and `stab_pend` stays 0.
- R5: With `pin_mask`=0, `pwdn_n` low acts like `pd_sw` after a two-stage synchronizer, so it takes effect on the third edge. With `pin_mask`=1 the pin has no effect on any output.
- R6: With `xtal_sel`=1, a power-down from `pd_sw`, from the unmasked pin or from a floppy low-power request drives `xtal_en` to 0 and all enables to 0.
- R7: When `xtal_en` returns to 1, `stab_pend` is 1 for exactly STAB_CYCLES cycles. During that time `fdc_ready` is 0 even though `clk_en[2]` is 1. While the crystal is off, `stab_pend` is 0.
- R8: `gclk[i]` pulses high with `clk` only when `clk_en[i]` was 1 during the preceding low phase. Otherwise it stays low.
- R9: If `fdc_lp_req` and `fdc_wake` occur in the same cycle, the request wins and the floppy stays stopped.
- R10: `fdc_ready` equals `clk_en[2]` whenever no stabilization is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_en | input | 3 | Function enables: 0 channel A, 1 channel B, 2 floppy |
| pd_sw | input | 1 | Software power-down bit |
| xtal_sel | input | 1 | 1: power-down also stops the crystal |
| pin_mask | input | 1 | 1: ignore the external power-down pin |
| pwdn_n | input | 1 | External power-down pin, active low, asynchronous |
| fdc_lp_req | input | 1 | Floppy low-power request pulse |
| fdc_wake | input | 1 | Floppy wake pulse |
| clk_en | output | 3 | Registered clock enables per function |
| gclk | output | 3 | Glitch-free gated clocks per function |
| xtal_en | output | 1 | Crystal oscillator enable |
| stab_pend | output | 1 | Crystal stabilization in progress |
| fdc_ready | output | 1 | Floppy ready, held low while stabilizing |

## Verification
A vector table sweeps the enables and the power-control word across all three depths. It separates a single-function stop from an all-clock stop by whether the crystal enable stays high, and a masked pin from an honoured pin by whether the enables drop. Directed sequences exercise the floppy request paths with each crystal-select value. These show whether the crystal stops and whether a wake starts stabilization. They also cover request and wake colliding in one cycle. The pending window is counted edge by edge to catch an off-by-one, and the gated clocks are sampled while the clock is high to tell an enabled gate from a closed one.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NFN    = 3;
  localparam int FN_FDC = 2;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_FUNC = 2'd1,
    PM_ALL  = 2'd2,
    PM_XTAL = 2'd3
  } pm_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_n;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pdc_mode_ctl.sv
module pdc_mode_ctl
  import pdc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NFN-1:0] fn_en,
  input  logic           pd_sw,
  input  logic           xtal_sel,
  input  logic           pin_mask,
  input  logic           pin_low_s,
  input  logic           fdc_lp_req,
  input  logic           fdc_wake,
  output logic [NFN-1:0] en_q,
  output logic           xtal_n,
  output logic           xtal_q
);
  pm_e            mode_q, mode_n;
  logic           lp_q, lp_n;
  logic           glob_pd;
  logic [NFN-1:0] en_n;
  logic           fn_run;

  always_comb begin
    lp_n = lp_q;
    if (fdc_wake)   lp_n = 1'b0;
    if (fdc_lp_req) lp_n = 1'b1;
    glob_pd = pd_sw | (~pin_mask & pin_low_s);
    if (xtal_sel && (glob_pd || lp_n))    mode_n = PM_XTAL;
    else if (glob_pd)                     mode_n = PM_ALL;
    else if (lp_n || (fn_en != '1))       mode_n = PM_FUNC;
    else                                  mode_n = PM_RUN;
    fn_run = (mode_n == PM_RUN) || (mode_n == PM_FUNC);
    xtal_n = (mode_n != PM_XTAL);
  end

  for (genvar i = 0; i < NFN; i++) begin : g_en
    if (i == FN_FDC) begin : g_fdc
      assign en_n[i] = fn_en[i] & fn_run & ~lp_n;
    end else begin : g_uart
      assign en_n[i] = fn_en[i] & fn_run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_RUN;
      lp_q   <= 1'b0;
      en_q   <= '0;
      xtal_q <= 1'b1;
    end else begin
      mode_q <= mode_n;
      lp_q   <= lp_n;
      en_q   <= en_n;
      xtal_q <= xtal_n;
    end
  end
endmodule

// File: rtl/pdc_stab_timer.sv
module pdc_stab_timer #(
  parameter int STAB_CYCLES = 1600000,
  localparam int CW = $clog2(STAB_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_req,
  output logic pend_q
);
  localparam logic [CW-1:0] LOAD = CW'(STAB_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_n;

  always_comb begin
    cnt_n  = cnt_q;
    pend_n = pend_q;
    if (!xtal_req) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else if (!prev_q) begin
      cnt_n  = LOAD;
      pend_n = 1'b1;
    end else if (pend_q) begin
      if (cnt_q == ONE) begin
        cnt_n  = '0;
        pend_n = 1'b0;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= xtal_req;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/pdc_clk_gate.sv
module pdc_clk_gate #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic [N-1:0] en,
  output logic [N-1:0] gclk
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    logic lat;
    always_latch begin
      if (!clk) lat = en[i];
    end
    assign gclk[i] = clk & lat;
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pdc_pkg::*;
#(
  parameter int STAB_CYCLES = 1600000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fn_en,
  input  logic       pd_sw,
  input  logic       xtal_sel,
  input  logic       pin_mask,
  input  logic       pwdn_n,
  input  logic       fdc_lp_req,
  input  logic       fdc_wake,
  output logic [2:0] clk_en,
  output logic [2:0] gclk,
  output logic       xtal_en,
  output logic       stab_pend,
  output logic       fdc_ready
);
  logic irst_n;
  logic pin_s;
  logic xtal_n;

  pdc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(irst_n)
  );

  pdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(irst_n), .d(pwdn_n), .q(pin_s)
  );

  pdc_mode_ctl u_mode (
    .clk(clk), .rst_n(irst_n), .fn_en(fn_en), .pd_sw(pd_sw),
    .xtal_sel(xtal_sel), .pin_mask(pin_mask), .pin_low_s(~pin_s),
    .fdc_lp_req(fdc_lp_req), .fdc_wake(fdc_wake),
    .en_q(clk_en), .xtal_n(xtal_n), .xtal_q(xtal_en)
  );

  pdc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk(clk), .rst_n(irst_n), .xtal_req(xtal_n), .pend_q(stab_pend)
  );

  pdc_clk_gate #(.N(NFN)) u_gate (
    .clk(clk), .en(clk_en), .gclk(gclk)
  );

  assign fdc_ready = clk_en[FN_FDC] & ~stab_pend;
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] fn_en,
  input logic       pd_sw,
  input logic       xtal_sel,
  input logic [2:0] clk_en,
  input logic       xtal_en,
  input logic       stab_pend,
  input logic       fdc_ready
);
  a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_en == 3'b000) |=> (clk_en == 3'b000));

  a_r4_swpd_stops_all: assert property (@(posedge clk) disable iff (!rst_n)
    pd_sw |=> (clk_en == 3'b000));

  a_r6_xtal_off_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |-> (clk_en == 3'b000));

  a_r6_swpd_sel_stops_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_sw && xtal_sel) |=> !xtal_en);

  a_r7_rise_starts_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_en) |-> stab_pend);

  a_r7_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    stab_pend |-> !fdc_ready);

  a_r7_no_pend_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |-> !stab_pend);

  a_r10_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !stab_pend |-> (fdc_ready == clk_en[2]));
endmodule

bind pwr_clk_ctrl pdc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fn_en(fn_en), .pd_sw(pd_sw),
  .xtal_sel(xtal_sel), .clk_en(clk_en), .xtal_en(xtal_en),
  .stab_pend(stab_pend), .fdc_ready(fdc_ready)
);

// File: tb/tb_pwr_clk_ctrl.sv
module tb_pwr_clk_ctrl;
  localparam int S = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] fn_en;
  logic       pd_sw, xtal_sel, pin_mask, pwdn_n, fdc_lp_req, fdc_wake;
  logic [2:0] clk_en, gclk;
  logic       xtal_en, stab_pend, fdc_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwr_clk_ctrl #(.STAB_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .fn_en(fn_en), .pd_sw(pd_sw),
    .xtal_sel(xtal_sel), .pin_mask(pin_mask), .pwdn_n(pwdn_n),
    .fdc_lp_req(fdc_lp_req), .fdc_wake(fdc_wake),
    .clk_en(clk_en), .gclk(gclk), .xtal_en(xtal_en),
    .stab_pend(stab_pend), .fdc_ready(fdc_ready)
  );

  // {fn_en, pd_sw, xtal_sel, pin_mask, pwdn_n, exp clk_en, exp xtal_en}
  localparam logic [10:0] VEC [10] = '{
    {3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1},
    {3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101, 1'b1},
    {3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 1'b1},
    {3'b111, 1'b1, 1'b0, 1'b0, 1'b1, 3'b000, 1'b1},
    {3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1},
    {3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1},
    {3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0},
    {3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0},
    {3'b011, 1'b0, 1'b0, 1'b1, 1'b1, 3'b011, 1'b1},
    {3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fn_en = 3'b111; pd_sw = 0; xtal_sel = 0; pin_mask = 0; pwdn_n = 1;
    fdc_lp_req = 0; fdc_wake = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 clk_en", clk_en, 0);
    chk("R1 xtal_en", xtal_en, 1);
    chk("R1 stab_pend", stab_pend, 0);
    chk("R1 fdc_ready", fdc_ready, 0);
    chk("R1 gclk", gclk, 0);
    rst_n = 1'b1;
    step(4);
    chk("R2 run all", clk_en, 7);

    // R2 R4 R5 R6 table walk
    for (int i = 0; i < 10; i++) begin
      {fn_en, pd_sw, xtal_sel, pin_mask, pwdn_n} = VEC[i][10:4];
      step(3);
      chk($sformatf("R2/R4/R5/R6 vec%0d clk_en", i), clk_en, VEC[i][3:1]);
      chk($sformatf("R2/R4/R5/R6 vec%0d xtal_en", i), xtal_en, VEC[i][0]);
    end

    idle_inputs();
    step(S + 5);
    chk("R10 ready steady", fdc_ready, 1);

    // R5 pin latency: takes effect on the third edge
    pwdn_n = 0;
    step(2);
    chk("R5 pin not yet", clk_en, 7);
    step(1);
    chk("R5 pin effect", clk_en, 0);
    pwdn_n = 1;
    step(3);

    // R4 wake from all-stop: no wait
    pd_sw = 1; step(1);
    chk("R4 all off", clk_en, 0);
    chk("R4 xtal on", xtal_en, 1);
    pd_sw = 0; step(1);
    chk("R4 restore", clk_en, 7);
    chk("R4 no pend", stab_pend, 0);

    // R3 floppy low-power, crystal kept
    fdc_lp_req = 1; step(1); fdc_lp_req = 0;
    chk("R3 fdc off", clk_en, 3);
    chk("R3 xtal on", xtal_en, 1);
    step(2);
    chk("R3 stays off", clk_en, 3);
    fdc_wake = 1; step(1); fdc_wake = 0;
    chk("R3 fdc back", clk_en, 7);
    chk("R3 ready no wait", fdc_ready, 1);

    // R9 request and wake together
    fdc_lp_req = 1; fdc_wake = 1; step(1);
    fdc_lp_req = 0; fdc_wake = 0;
    chk("R9 req wins", clk_en, 3);
    fdc_wake = 1; step(1); fdc_wake = 0;

    // R8 gated clocks
    fn_en = 3'b001; step(2);
    chk("R8 gclk open", gclk, 1);
    chk("R8 enables", clk_en, 1);
    fn_en = 3'b111; step(2);

    // R7 crystal stop via software, restart timing
    xtal_sel = 1; pd_sw = 1; step(1);
    chk("R6 xtal off", xtal_en, 0);
    chk("R7 no pend off", stab_pend, 0);
    step(2);
    pd_sw = 0; step(1);
    chk("R7 xtal back", xtal_en, 1);
    chk("R7 pend set", stab_pend, 1);
    chk("R7 fdc en", clk_en, 7);
    chk("R7 ready held", fdc_ready, 0);
    step(S - 1);
    chk("R7 pend last", stab_pend, 1);
    step(1);
    chk("R7 pend clear", stab_pend, 0);
    chk("R7 ready", fdc_ready, 1);

    // R6 floppy request with crystal stop
    fdc_lp_req = 1; step(1); fdc_lp_req = 0;
    chk("R6 fdc xtal off", xtal_en, 0);
    chk("R6 fdc all off", clk_en, 0);
    fdc_wake = 1; step(1); fdc_wake = 0;
    chk("R7 fdc wake pend", stab_pend, 1);
    chk("R7 fdc wake en", clk_en, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule